// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a serial stereo audio stream into parallel sample words. It watches a bit clock, a word-select line and a serial data line, which are all already synchronous to the system clock. It oversamples them, locks onto the word-select framing and shifts in each sample most-significant bit first. Completed samples leave on a valid/ready stream together with a channel tag. A 3-bit format selector sets the sample length and chooses between plain right-justified words and two packed layouts that carry a left/right pair in one word. A mono switch replaces every right sample with the most recent left sample. A loopback switch takes serial data from the local transmitter's output instead of the external pin.

A controller programs the format, mono and loopback inputs while `enable` is low, then raises `enable`. The receiver's control path is a five-state machine:

- **IDLE**: entered whenever `enable` is low. The transition *start* leads to ARM.
- **ARM**: records the first word-select level. The transition *armed* leads to HUNT.
- **HUNT**: waits for a word-select change. The transition *lock* leads to SHIFT.
- **SHIFT**: collects data bits. The transition *sample complete* leads to SKIP. The transition *slot restart* stays in SHIFT when word-select changes early.
- **SKIP**: ignores padding bits. The transition *next slot* leads back to SHIFT on a word-select change.

The transition *disable* returns any state to IDLE.

The output register holds a word until it is accepted. A word that completes while the previous one is still waiting is discarded and raises a sticky overrun flag.

Top module: `i2s_stereo_rx`

## Requirements
- R1: `fmt_sel` selects the sample length: 0=32, 1=24, 2=20, 3=18, 4=16, 6=8 bits, each sent as one right-justified word per channel with all bits above the length zero. Codes 5 and 7 are packed layouts (R4, R5).
- R2: Data is sampled on rising bit-clock edges. The first bit of a slot (its MSB) is the one sampled one bit clock after the edge at which a new word-select level is first seen. Word-select low marks a left slot (`out_chan`=0) and high marks a right slot (`out_chan`=1). No sample is produced before the first word-select change after enable.
- R3: Bits in a slot beyond the sample length are ignored, so any slot at least as long as the sample length is accepted, including 24-bit and 32-bit slots for 18, 20 and 24-bit data.
- R4: Code 5 (16-bit packed) sends one word per left/right pair, left sample in bits 15:0 and right sample in bits 31:16, tagged `out_chan`=0.
- R5: Code 7 (8-bit packed) sends one word per pair, left sample in bits 7:0 and right sample in bits 15:8, bits 31:16 zero, tagged `out_chan`=0.
- R6: With `mono_en`=1, each right slot produces the preceding left sample in place of the received right data, in every format.
- R7: With `loop_en`=1, serial data is taken from `tx_sd` and `sd_in` has no effect. With `loop_en`=0, `tx_sd` has no effect.
- R8: `out_valid` and `out_data` hold until `out_ready` is high. A word completing while an unaccepted word is waiting is dropped and sets `overrun`, which stays set while enabled.
- R9: After reset, and one cycle after `enable` goes low, `out_valid` and `overrun` are 0.
- R10: If word-select changes before a slot has delivered the full sample length, the partial sample is discarded and a new slot begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver run; configuration changes only while low |
| fmt_sel | input | 3 | Sample length / packing code |
| mono_en | input | 1 | Copy left sample into right channel |
| loop_en | input | 1 | Take serial data from the transmitter output |
| sck | input | 1 | Serial bit clock (synchronous, oversampled) |
| ws | input | 1 | Word select, low = left |
| sd_in | input | 1 | Serial data from the pin |
| tx_sd | input | 1 | Serial data from the local transmitter |
| out_ready | input | 1 | Stream consumer ready |
| out_valid | output | 1 | Stream word valid |
| out_data | output | DATA_W | Stream word |
| out_chan | output | 1 | Channel tag, 0 = left or packed pair |
| overrun | output | 1 | Sticky dropped-word flag |

## Verification
Every format code is swept with mono on and off and with loopback on and off. Sample values are generated so that neighbouring slots and channels differ, and padding bits are driven as ones. A mix-up of channels, an off-by-one bit alignment, a wrong packing half or leaking padding therefore shows up as a wrong word. The unused data line carries the inverse of the stream, so a loopback multiplexer that picks the wrong source corrupts every word. Extra runs use 24-bit, 16-bit and 8-bit slots to show that slot width does not matter, and a run with slots shorter than the sample length must produce nothing. A run with the consumer stalled checks that the first word is held and that the later words are dropped and flagged.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ARM,
        RX_HUNT,
        RX_SHIFT,
        RX_SKIP
    } rx_state_e;

    localparam logic [2:0] FMT_PACK16 = 3'd5;
    localparam logic [2:0] FMT_PACK8  = 3'd7;

    // Number of data bits carried per slot for a format code
    function automatic logic [5:0] fmt_bits(input logic [2:0] f);
        logic [5:0] b;
        unique case (f)
            3'd0:    b = 6'd32;
            3'd1:    b = 6'd24;
            3'd2:    b = 6'd20;
            3'd3:    b = 6'd18;
            3'd4,
            3'd5:    b = 6'd16;
            default: b = 6'd8;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/i2s_rx_frontend.sv
module i2s_rx_frontend (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic sck,
    input  logic ws,
    input  logic sd_in,
    input  logic tx_sd,
    output logic bit_stb,
    output logic bit_val,
    output logic ws_val
);
    logic sck_q;
    logic sd_sel;

    assign sd_sel = loop_en ? tx_sd : sd_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
            ws_val  <= 1'b0;
        end else begin
            sck_q   <= sck;
            bit_stb <= sck && !sck_q;
            if (sck && !sck_q) begin
                bit_val <= sd_sel;
                ws_val  <= ws;
            end
        end
    end
endmodule

// File: rtl/i2s_rx_shifter.sv
module i2s_rx_shifter
    import i2s_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2:0]        fmt_sel,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              ws_val,
    output logic              done,
    output logic [DATA_W-1:0] sample,
    output logic              sample_chan
);
    localparam int CNT_W = $clog2(DATA_W) + 1;

    rx_state_e         state, state_nx;
    logic              ws_prev;
    logic              chan;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sr;
    logic [DATA_W-1:0] shifted;
    logic              changed;
    logic              last_bit;
    logic [5:0]        len;

    assign len      = fmt_bits(fmt_sel);
    assign changed  = ws_val != ws_prev;
    assign shifted  = {sr[DATA_W-2:0], bit_val};
    assign last_bit = cnt == CNT_W'(len - 6'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (enable) state_nx = RX_ARM;
            RX_ARM:   if (bit_stb) state_nx = RX_HUNT;
            RX_HUNT:  if (bit_stb && changed) state_nx = RX_SHIFT;
            RX_SHIFT: if (bit_stb && changed) state_nx = RX_SHIFT;
                      else if (bit_stb && last_bit) state_nx = RX_SKIP;
            RX_SKIP:  if (bit_stb && changed) state_nx = RX_SHIFT;
            default:  state_nx = RX_IDLE;
        endcase
        if (!enable) state_nx = RX_IDLE;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev     <= 1'b0;
            chan        <= 1'b0;
            cnt         <= '0;
            sr          <= '0;
            done        <= 1'b0;
            sample      <= '0;
            sample_chan <= 1'b0;
        end else begin
            done <= 1'b0;
            if (enable && state != RX_IDLE && bit_stb) begin
                ws_prev <= ws_val;
                if (state == RX_SHIFT) begin
                    sr  <= shifted;
                    cnt <= cnt + 1'b1;
                    if (last_bit) begin
                        done        <= 1'b1;
                        sample      <= shifted;
                        sample_chan <= chan;
                    end
                end
                if (state != RX_ARM && changed) begin
                    cnt  <= '0;
                    sr   <= '0;
                    chan <= ws_val;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_rx_packer.sv
module i2s_rx_packer
    import i2s_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2:0]        fmt_sel,
    input  logic              mono_en,
    input  logic              done,
    input  logic [DATA_W-1:0] sample,
    input  logic              sample_chan,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_chan,
    output logic              overrun
);
    localparam int HALF = DATA_W / 2;
    localparam int QTR  = DATA_W / 4;

    logic [DATA_W-1:0] left_hold;
    logic              left_seen;
    logic              packed_fmt;
    logic [DATA_W-1:0] right_sel;
    logic              emit;
    logic [DATA_W-1:0] edata;
    logic              echan;

    assign packed_fmt = (fmt_sel == FMT_PACK16) || (fmt_sel == FMT_PACK8);
    assign right_sel  = mono_en ? left_hold : sample;

    always_comb begin
        emit  = 1'b0;
        edata = '0;
        echan = 1'b0;
        if (done) begin
            if (!sample_chan) begin
                if (!packed_fmt) begin
                    emit  = 1'b1;
                    edata = sample;
                end
            end else if (left_seen || !(packed_fmt || mono_en)) begin
                emit = 1'b1;
                if (fmt_sel == FMT_PACK16) begin
                    edata = {right_sel[HALF-1:0], left_hold[HALF-1:0]};
                end else if (fmt_sel == FMT_PACK8) begin
                    edata = {{HALF{1'b0}}, right_sel[QTR-1:0], left_hold[QTR-1:0]};
                end else begin
                    edata = right_sel;
                    echan = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_chan  <= 1'b0;
            overrun   <= 1'b0;
            left_hold <= '0;
            left_seen <= 1'b0;
        end else if (!enable) begin
            out_valid <= 1'b0;
            overrun   <= 1'b0;
            left_seen <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (emit) begin
                if (out_valid && !out_ready) begin
                    overrun <= 1'b1;
                end else begin
                    out_valid <= 1'b1;
                    out_data  <= edata;
                    out_chan  <= echan;
                end
            end
            if (done) begin
                if (!sample_chan) begin
                    left_hold <= sample;
                    left_seen <= 1'b1;
                end else begin
                    left_seen <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2:0]        fmt_sel,
    input  logic              mono_en,
    input  logic              loop_en,
    input  logic              sck,
    input  logic              ws,
    input  logic              sd_in,
    input  logic              tx_sd,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_chan,
    output logic              overrun
);
    logic              bit_stb;
    logic              bit_val;
    logic              ws_val;
    logic              done;
    logic [DATA_W-1:0] sample;
    logic              sample_chan;

    i2s_rx_frontend u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (loop_en),
        .sck     (sck),
        .ws      (ws),
        .sd_in   (sd_in),
        .tx_sd   (tx_sd),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .ws_val  (ws_val)
    );

    i2s_rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .fmt_sel     (fmt_sel),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .ws_val      (ws_val),
        .done        (done),
        .sample      (sample),
        .sample_chan (sample_chan)
    );

    i2s_rx_packer #(.DATA_W(DATA_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .fmt_sel     (fmt_sel),
        .mono_en     (mono_en),
        .done        (done),
        .sample      (sample),
        .sample_chan (sample_chan),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_chan    (out_chan),
        .overrun     (overrun)
    );
endmodule

// File: rtl/i2s_stereo_rx_chk.sv
module i2s_stereo_rx_chk
    import i2s_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [2:0]        fmt_sel,
    input logic              out_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_chan,
    input logic              overrun
);
    logic [5:0] used_w;
    assign used_w = (fmt_sel == FMT_PACK8) ? 6'd16 : fmt_bits(fmt_sel);

    // R8: a waiting word is held unchanged until accepted
    assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && out_valid && !out_ready) |=> (!enable || (out_valid && $stable(out_data))));

    // R8: the overrun flag is sticky while enabled
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && overrun) |=> (overrun || !enable));

    // R9: disabling clears the stream valid and overrun flag
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!out_valid && !overrun));

    // R1: bits above the used width are zero
    assert_right_justified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && out_valid && fmt_sel != 3'd0 && fmt_sel != FMT_PACK16)
            |-> ((DATA_W'(out_data) >> used_w) == '0));

    // R5: packed words carry the pair tag 0
    assert_packed_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && out_valid && (fmt_sel == FMT_PACK16 || fmt_sel == FMT_PACK8)) |-> !out_chan);
endmodule

bind i2s_stereo_rx i2s_stereo_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fmt_sel   (fmt_sel),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .overrun   (overrun)
);

// File: tb/tb_i2s_stereo_rx.sv
`timescale 1ns/1ps
module tb_i2s_stereo_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic        mono_en = 1'b0;
    logic        loop_en = 1'b0;
    logic        sck = 1'b0;
    logic        ws = 1'b1;
    logic        sd_in = 1'b0;
    logic        tx_sd = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_chan;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [32:0] cap[$];
    logic [32:0] expq[$];
    logic [31:0] smp[4];

    always #10 clk = ~clk;

    i2s_stereo_rx dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fmt_sel(fmt_sel),
        .mono_en(mono_en), .loop_en(loop_en), .sck(sck), .ws(ws),
        .sd_in(sd_in), .tx_sd(tx_sd), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
        .overrun(overrun)
    );

    always @(negedge clk) if (out_valid && out_ready) cap.push_back({out_chan, out_data});

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int blen(input int code);
        case (code)
            0: return 32; 1: return 24; 2: return 20; 3: return 18;
            4, 5: return 16; default: return 8;
        endcase
    endfunction

    task automatic set_cfg(input int code, input bit mono, input bit lb);
        @(posedge clk); #2; enable = 1'b0; sck = 1'b0;
        repeat (3) @(posedge clk);
        #2; fmt_sel = code[2:0]; mono_en = mono; loop_en = lb; ws = 1'b1;
        repeat (2) @(posedge clk);
        #2; enable = 1'b1;
        repeat (2) @(posedge clk);
        cap.delete();
    endtask

    task automatic send_bit(input logic w, input logic d, input bit lb);
        @(posedge clk); #2;
        sck = 1'b0; ws = w;
        if (lb) begin tx_sd = d; sd_in = ~d; end
        else begin sd_in = d; tx_sd = ~d; end
        @(posedge clk); #2; sck = 1'b1;
        @(posedge clk);
    endtask

    // Four slots L,R,L,R; word select leads data by one bit; padding driven as ones
    task automatic run_stream(input int bits, input int slot, input bit lb);
        for (int k = -3; k < 4 * slot + 2; k++) begin
            logic w, d;
            w = (k + 1 < 0) ? 1'b1 : 1'(((k + 1) / slot) % 2);
            if (k >= 0 && k < 4 * slot) begin
                if ((k % slot) < bits) d = smp[k / slot][bits - 1 - (k % slot)];
                else d = 1'b1;
            end else d = 1'b0;
            send_bit(w, d, lb);
        end
        repeat (8) @(posedge clk);
    endtask

    task automatic make_samples(input int seed, input int bits);
        logic [63:0] m;
        m = (64'd1 << bits) - 64'd1;
        for (int s = 0; s < 4; s++)
            smp[s] = ((32'h9E37_79B9 * 32'(seed * 4 + s + 1)) ^ (32'hA5A5_0000 >> s)) & m[31:0];
    endtask

    task automatic run_case(input int code, input bit mono, input bit lb, input int slot,
                            input int seed, input string req);
        int bits;
        bits = blen(code);
        set_cfg(code, mono, lb);
        make_samples(seed, bits);
        run_stream(bits, slot, lb);
        expq.delete();
        for (int p = 0; p < 2; p++) begin
            logic [31:0] l, r;
            l = smp[2 * p];
            r = mono ? l : smp[2 * p + 1];
            if (code == 5) expq.push_back({1'b0, r[15:0], l[15:0]});
            else if (code == 7) expq.push_back({1'b0, 16'h0, r[7:0], l[7:0]});
            else begin
                expq.push_back({1'b0, l});
                expq.push_back({1'b1, r});
            end
        end
        chk(cap.size() == expq.size(), req, 64'(cap.size()), 64'(expq.size()));
        for (int i = 0; i < expq.size() && i < cap.size(); i++)
            chk(cap[i] === expq[i], req, 64'(cap[i]), 64'(expq[i]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
        chk(overrun == 1'b0, "R9 reset overrun", 64'(overrun), 64'd0);

        // Sweep all formats x mono x loopback with 32-bit slots
        for (int code = 0; code < 8; code++)
            for (int mono = 0; mono < 2; mono++)
                for (int lb = 0; lb < 2; lb++) begin
                    string req;
                    if (code == 5) req = "R4 R2";
                    else if (code == 7) req = "R5 R2";
                    else if (mono != 0) req = "R6 R1";
                    else if (lb != 0) req = "R7 R1";
                    else req = "R1 R2 R3";
                    if (mono != 0 && (code == 5 || code == 7)) req = {req, " R6"};
                    if (lb != 0) req = {req, " R7"};
                    run_case(code, 1'(mono), 1'(lb), 32, code * 4 + mono * 2 + lb, req);
                end

        // Narrower slots, at least as long as the sample
        run_case(1, 1'b0, 1'b0, 24, 40, "R3 slot24 len24");
        run_case(2, 1'b0, 1'b0, 24, 41, "R3 slot24 len20");
        run_case(3, 1'b0, 1'b0, 24, 42, "R3 slot24 len18");
        run_case(4, 1'b0, 1'b0, 16, 43, "R3 slot16 len16");
        run_case(6, 1'b0, 1'b1, 8,  44, "R3 slot8 len8");
        run_case(5, 1'b1, 1'b0, 16, 45, "R3 R4 R6 slot16");

        // Slots shorter than the sample length produce nothing
        set_cfg(1, 1'b0, 1'b0);
        make_samples(50, 24);
        run_stream(24, 16, 1'b0);
        chk(cap.size() == 0, "R10 short slot", 64'(cap.size()), 64'd0);

        // Stalled consumer: first word held, later ones dropped
        set_cfg(4, 1'b0, 1'b0);
        @(posedge clk); #2; out_ready = 1'b0;
        make_samples(60, 16);
        run_stream(16, 32, 1'b0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 held valid", 64'(out_valid), 64'd1);
        chk(out_data == smp[0], "R8 held data", 64'(out_data), 64'(smp[0]));
        chk(out_chan == 1'b0, "R8 held chan", 64'(out_chan), 64'd0);
        chk(overrun == 1'b1, "R8 overrun set", 64'(overrun), 64'd1);
        @(posedge clk); #2; out_ready = 1'b1;
        repeat (4) @(posedge clk);
        chk(cap.size() == 1, "R8 single word", 64'(cap.size()), 64'd1);
        if (cap.size() > 0) chk(cap[0][31:0] == smp[0], "R8 accepted data", 64'(cap[0]), 64'(smp[0]));
        chk(overrun == 1'b1, "R8 overrun sticky", 64'(overrun), 64'd1);
        @(posedge clk); #2; enable = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(overrun == 1'b0, "R9 disable overrun", 64'(overrun), 64'd0);
        chk(out_valid == 1'b0, "R9 disable valid", 64'(out_valid), 64'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule